// File: doc/BRIEF.md
# SMRAM Window Decoder

This block decodes host addresses against the 128 KB system-management memory window that sits at host addresses A0000h to BFFFFh. Each request carries a 32-bit address, a flag saying the processor is in system-management mode, and a flag that separates code fetches from data cycles. Three configuration bytes come with it: a low relocation byte, a high relocation byte, and a control byte. From these the block decides whether it claims the cycle, whether a claimed cycle goes to DRAM or out to the bus, and which DRAM address it uses.

The DRAM target of the window can be moved in 1 MB steps anywhere in a 32-bit space. The twelve relocation bits form address bits 31:20, and the window's own offset A0000h is ORed into the low bits. The window is always open in management mode. Outside that mode it opens only when a local-access bit in the control byte is set. A split bit in the same byte sends data cycles that hit the window to the bus and keeps code fetches on DRAM. Cycles outside the window are never claimed and pass to the bus unchanged.

The decision is registered. Configuration bytes are sampled together with the request, so a configuration change takes effect from the next request on. A request already accepted keeps the routing it was given.

Top module: `smram_window_decoder`

## Requirements
- R1: While reset is held and right after it, respValid, respHit and respToDram are 0 and respAddr is 0.
- R2: A request whose address is below A0000h or above BFFFFh gives respHit=0 and respToDram=0, and respAddr equals the request address. This applies in every mode and for any upper address bits.
- R3: In management mode (smmActive=1), a request inside A0000h..BFFFFh gives respHit=1, whatever the state of control-byte bit 0.
- R4: Outside management mode, a request inside the window gives respHit=1 only when control-byte bit 0 (local access) is 1. Otherwise respHit=0, respToDram=0 and respAddr equals the request address.
- R5: A claimed request that goes to DRAM returns respAddr = base + (address − A0000h). Here base = ({high byte bits 3:0, low byte} << 20) | A0000h. Bits 7:4 of the high byte have no effect.
- R6: When control-byte bit 5 (split) is 1, a claimed data cycle (isCode=0) gives respHit=1, respToDram=0 and respAddr equal to the request address. A claimed code fetch (isCode=1) goes to DRAM with the translated address. When bit 5 is 0, every claimed cycle goes to DRAM.
- R7: The response comes one clock after the request. The configuration bytes are sampled in the request's own cycle, so a change in the next cycle does not alter the earlier response.
- R8: With low byte 00h and high byte 20h, the translated address equals the host address (identity mapping).
- R9: respValid is 1 exactly in the cycle after a cycle with reqValid=1, and 0 after a cycle with reqValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Host address of the request |
| smmActive | input | 1 | Processor is in management mode |
| isCode | input | 1 | 1 = code fetch, 0 = data cycle |
| cfgBaseLo | input | 8 | Relocation bits 27:20 |
| cfgBaseHi | input | 8 | Bits 3:0 are relocation bits 31:28; bits 7:4 are ignored |
| cfgCtrl | input | 8 | Bit 0 local access, bit 5 data/code split; other bits ignored |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Window claimed the request |
| respToDram | output | 1 | Claimed request is routed to DRAM |
| respAddr | output | 32 | Translated DRAM address, or the host address when not routed to DRAM |

## Verification
Two things can happen in the same cycle: a configuration change and the delivery of a response that was decided under the old configuration. The bench provokes this by issuing back-to-back requests to the same window address while the control and relocation bytes change between them, for example a closed window followed by an open one, or one relocation base followed by another. Each response is judged against an expected item computed from the configuration in force on its own request cycle. So a response that picked up the newer bytes shows up as a mismatch.

// File: rtl/smram_win_pkg.sv
package smram_win_pkg;
  // Strobes from the decode control to the result datapath
  typedef struct packed {
    logic capture;  // a request is accepted this cycle
    logic claim;    // the window claims it
    logic toDram;   // the claimed request is routed to DRAM
  } winStrobe_t;
endpackage

// File: rtl/smram_win_ctrl.sv
module smram_win_ctrl
  import smram_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter int WIN_LOG2 = 17,
  parameter int LOCAL_BIT = 0,
  parameter int SPLIT_BIT = 5
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              smmActive,
  input  logic              isCode,
  input  logic [7:0]        cfgCtrl,
  output winStrobe_t        strobe
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic inWindow;
  logic windowOpen;
  logic dataToBus;
  logic unusedCtrl;

  assign inWindow   = (reqAddr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign windowOpen = smmActive | cfgCtrl[LOCAL_BIT];
  assign dataToBus  = cfgCtrl[SPLIT_BIT] & ~isCode;
  assign unusedCtrl = ^cfgCtrl;

  always_comb begin
    strobe.capture = reqValid;
    strobe.claim   = reqValid & inWindow & windowOpen;
    strobe.toDram  = strobe.claim & ~dataToBus;
  end
endmodule

// File: rtl/smram_win_datapath.sv
module smram_win_datapath
  import smram_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter int WIN_LOG2 = 17,
  parameter int RELOC_SHIFT = 20,
  parameter int RELOC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        cfgBaseLo,
  input  logic [RELOC_W-9:0] cfgBaseHi,
  output logic              respValid,
  output logic              respHit,
  output logic              respToDram,
  output logic [ADDR_W-1:0] respAddr
);
  logic [RELOC_W-1:0] relocField;
  logic [ADDR_W-1:0]  relocBase;
  logic [ADDR_W-1:0]  winOffset;
  logic [ADDR_W-1:0]  translated;

  assign relocField = {cfgBaseHi, cfgBaseLo};
  assign relocBase  = (ADDR_W'(relocField) << RELOC_SHIFT) | WIN_BASE;
  assign winOffset  = reqAddr - WIN_BASE;
  assign translated = relocBase + winOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respToDram <= 1'b0;
      respAddr   <= '0;
    end else begin
      respValid  <= strobe.capture;
      respHit    <= strobe.claim;
      respToDram <= strobe.toDram;
      if (strobe.capture)
        respAddr <= strobe.toDram ? translated : reqAddr;
    end
  end

  // R6
  route_implies_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    respToDram |-> respHit);

  // R5
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toDram |=> respAddr[WIN_LOG2-1:0] == $past(reqAddr[WIN_LOG2-1:0]));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!respValid && !respHit && !respToDram));
endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
  import smram_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter int WIN_LOG2 = 17,
  parameter int RELOC_SHIFT = 20,
  parameter int RELOC_W = 12,
  parameter int LOCAL_BIT = 0,
  parameter int SPLIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              smmActive,
  input  logic              isCode,
  input  logic [7:0]        cfgBaseLo,
  input  logic [7:0]        cfgBaseHi,
  input  logic [7:0]        cfgCtrl,
  output logic              respValid,
  output logic              respHit,
  output logic              respToDram,
  output logic [ADDR_W-1:0] respAddr
);
  localparam int HI_W = RELOC_W - 8;
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ((ADDR_W'(1) << WIN_LOG2) - 1);

  winStrobe_t strobe;
  logic unusedHi;
  assign unusedHi = ^cfgBaseHi[7:HI_W];

  smram_win_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .LOCAL_BIT(LOCAL_BIT), .SPLIT_BIT(SPLIT_BIT)
  ) uCtrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .smmActive(smmActive),
    .isCode(isCode), .cfgCtrl(cfgCtrl), .strobe(strobe)
  );

  smram_win_datapath #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .RELOC_SHIFT(RELOC_SHIFT), .RELOC_W(RELOC_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .cfgBaseLo(cfgBaseLo), .cfgBaseHi(cfgBaseHi[HI_W-1:0]),
    .respValid(respValid), .respHit(respHit), .respToDram(respToDram),
    .respAddr(respAddr)
  );

  // R2
  outside_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqAddr < WIN_BASE || reqAddr > WIN_LAST))
      |=> (!respHit && !respToDram && respAddr == $past(reqAddr)));

  // R3
  smm_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && smmActive && reqAddr >= WIN_BASE && reqAddr <= WIN_LAST)
      |=> respHit);

  // R4
  closed_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !smmActive && !cfgCtrl[LOCAL_BIT]) |=> (!respHit && !respToDram));

  // R6
  split_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgCtrl[SPLIT_BIT] && !isCode) |=> !respToDram);

  // R9
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R9
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
endmodule

// File: tb/sim_smram_window_decoder.sv
module sim_smram_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        smmActive = 1'b0;
  logic        isCode = 1'b0;
  logic [7:0]  cfgBaseLo = 8'h00;
  logic [7:0]  cfgBaseHi = 8'h20;
  logic [7:0]  cfgCtrl = 8'h00;
  logic        respValid, respHit, respToDram;
  logic [31:0] respAddr;

  typedef struct {
    logic        hit;
    logic        dram;
    logic [31:0] addr;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smram_window_decoder u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .smmActive(smmActive), .isCode(isCode), .cfgBaseLo(cfgBaseLo),
    .cfgBaseHi(cfgBaseHi), .cfgCtrl(cfgCtrl), .respValid(respValid),
    .respHit(respHit), .respToDram(respToDram), .respAddr(respAddr)
  );

  // Reference model built from the requirements
  function automatic expItem_t model(input logic [31:0] a, input logic smm,
      input logic code, input logic [7:0] lo, input logic [7:0] hi,
      input logic [7:0] ctl, input string tag);
    expItem_t e;
    logic [31:0] base;
    logic inWin;
    base   = {hi[3:0], lo, 20'h00000} | 32'h000A_0000;
    inWin  = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    e.hit  = inWin && (smm || ctl[0]);
    e.dram = e.hit && !(ctl[5] && !code);
    e.addr = e.dram ? base + (a - 32'h000A_0000) : a;
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(input logic [31:0] a, input logic smm, input logic code,
      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ctl,
      input string tag);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = a;
    smmActive = smm;
    isCode    = code;
    cfgBaseLo = lo;
    cfgBaseHi = hi;
    cfgCtrl   = ctl;
    expQ.push_back(model(a, smm, code, lo, hi, ctl, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      reqAddr  = 32'h000A_5555;
      cfgCtrl  = 8'h21;
    end
  endtask

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && respValid) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R9: response with no request pending, addr=%h", respAddr);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (respHit !== e.hit || respToDram !== e.dram || respAddr !== e.addr) begin
          mismatched++;
          $display("FAIL %s: got hit=%b dram=%b addr=%h, expected hit=%b dram=%b addr=%h",
                   e.tag, respHit, respToDram, respAddr, e.hit, e.dram, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    compared++;
    if (respValid !== 1'b0 || respHit !== 1'b0 || respToDram !== 1'b0 || respAddr !== 32'h0) begin
      mismatched++;
      $display("FAIL R1: got valid=%b hit=%b dram=%b addr=%h, expected all zero",
               respValid, respHit, respToDram, respAddr);
    end
    rstN = 1'b1;
    @(negedge clk);
    compared++;
    if (respValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: got valid=%b after reset, expected 0", respValid);
    end

    send(32'h000A_1234, 1, 0, 8'h00, 8'h20, 8'h00, "R8");
    send(32'h000B_FFFF, 1, 1, 8'h00, 8'h20, 8'h00, "R8");
    send(32'h000B_FFFF, 1, 0, 8'h3C, 8'h05, 8'h00, "R3");
    send(32'h000A_0000, 1, 1, 8'h3C, 8'h05, 8'h00, "R3");
    send(32'h0009_FFFF, 1, 0, 8'h3C, 8'h05, 8'h01, "R2");
    send(32'h000C_0000, 1, 0, 8'h3C, 8'h05, 8'h01, "R2");
    send(32'h123A_0000, 1, 1, 8'h3C, 8'h05, 8'h01, "R2");
    send(32'h000A_8000, 0, 0, 8'h3C, 8'h05, 8'h00, "R4");
    send(32'h000A_8000, 0, 0, 8'h3C, 8'h05, 8'h01, "R4");
    send(32'h000A_4444, 1, 0, 8'h10, 8'h00, 8'h20, "R6");
    send(32'h000A_4444, 1, 1, 8'h10, 8'h00, 8'h20, "R6");
    send(32'h000B_0101, 0, 0, 8'h10, 8'h00, 8'h21, "R6");
    send(32'h000B_0101, 0, 1, 8'h10, 8'h00, 8'h21, "R6");
    send(32'h000B_0101, 0, 1, 8'h10, 8'h00, 8'h20, "R6");
    send(32'h000A_0ABC, 1, 0, 8'hFF, 8'hFF, 8'h00, "R5");
    send(32'h000A_0ABC, 1, 0, 8'hFF, 8'h0F, 8'h00, "R5");
    send(32'h000B_7777, 1, 1, 8'h81, 8'hA7, 8'h00, "R5");
    // R7: configuration changes between back-to-back requests
    send(32'h000A_2000, 0, 0, 8'h44, 8'h01, 8'h00, "R7");
    send(32'h000A_2000, 0, 0, 8'h44, 8'h01, 8'h01, "R7");
    send(32'h000A_2000, 0, 0, 8'h99, 8'h02, 8'h01, "R7");
    send(32'h000A_2000, 0, 0, 8'h99, 8'h02, 8'h21, "R7");
    send(32'h000A_2000, 1, 1, 8'h00, 8'h20, 8'h00, "R7");
    idle(3);
    // R9: no response after idle cycles
    compared++;
    if (respValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R9: got valid=%b after idle, expected 0", respValid);
    end
    send(32'h000A_FFFF, 1, 0, 8'h02, 8'h00, 8'h00, "R9");
    idle(1);
    send(32'h000A_0001, 0, 1, 8'h02, 8'h00, 8'h01, "R9");
    idle(3);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R9: got %0d pending responses, expected 0", expQ.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule